// File: doc/BRIEF.md
# Context-Tagged Software-Managed TLB

This block translates virtual addresses to physical addresses through a set-associative array of translation entries. Software fills and invalidates every entry itself through a small register window. Each entry carries an address-space tag. A lookup hits only when the entry's tag equals the low byte of the current-context register, its stored page number equals the page number of the looked-up address, and its valid flag is set. Because of this, translations for many address spaces can stay resident at the same time.

Lookups use a valid/ready pair on the request side and another on the result side. The translation is combinational, and the two handshakes are joined straight through. The result is valid in the same cycle as the request, and the requester sees the consumer's back-pressure unchanged on its ready output. A stalled requester must hold its address. The result then stays stable, as long as software does not write the register window in the meantime.

Software reaches an entry in three steps. It writes the entry index to the select register, then writes the high word (context tag and page number), then writes the low word (frame number and flags). To invalidate an entry, software rewrites its tag to the reserved value, all ones, which never produces a hit.

Top module: `ctlb_top`

## Requirements
- R1: After reset, every entry holds tag 0xFF, page number 0 and a low word of 0. The select and context registers read 0, and every lookup misses.
- R2: The window register at address 0 selects the entry. Only bits [5:0] are kept and read back. Index i names set i[3:0] and way i[5:4].
- R3: A write to window address 1 sets the selected entry's tag from bits [7:0] and its page number from bits [31:13]. Reading address 1 returns these fields in the same positions, with bits [12:8] as 0. This write does not change the entry's low word.
- R4: A write to window address 2 sets the selected entry's frame number from bits [31:13] and three flags: valid in bit 0, writable in bit 1 and executable in bit 2. Reading address 2 returns these fields, with bits [12:3] as 0. This write does not change the entry's tag or page number.
- R5: A lookup of address va examines the four ways of set va[16:13]. A way hits only when its page number equals va[31:13], its tag equals the context register's bits [7:0], and its valid flag is 1.
- R6: The context register lives at window address 3 and reads back all 32 bits. Its bits [31:8] have no effect on the tag compare.
- R7: An entry whose tag is 0xFF never hits, even when the context register's low byte is 0xFF.
- R8: On a hit, the physical address is {frame number, va[12:0]}, and the writable and executable outputs copy the entry's flags. On a miss, the physical address and both flags are 0.
- R9: When more than one way of a set hits, the lowest-numbered way supplies the result.
- R10: rsp_valid follows req_valid and req_ready follows rsp_ready within the same cycle. Suppose a result is stalled, the address is held and no window write occurs. Then the result stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request accepted |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_hit | output | 1 | A way matched |
| rsp_pa | output | 32 | Physical address, or 0 on a miss |
| rsp_wr | output | 1 | Writable flag of the hit entry |
| rsp_ex | output | 1 | Executable flag of the hit entry |
| reg_wr | input | 1 | Window write strobe |
| reg_addr | input | 2 | Window address: 0 select, 1 high, 2 low, 3 context |
| reg_wdata | input | 32 | Window write data |
| reg_rdata | output | 32 | Window read data for reg_addr |

## Verification
The bench builds the block with its default parameters: 16 sets of 4 ways, an 8-bit context tag and an 8 KB page. At that size, every one of the 64 entries can be written, read back and looked up under three contexts. A bench model derived from the requirements predicts every hit, miss and physical address. The small array also lets the bench place duplicate matches in one set, and try the reserved tag with the context low byte set to 0xFF. It also runs a held lookup under back-pressure over several cycles.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;

  typedef enum logic [1:0] {
    WIN_SEL = 2'd0,
    WIN_HI  = 2'd1,
    WIN_LO  = 2'd2,
    WIN_CTX = 2'd3
  } win_addr_e;

  localparam int FLAG_N     = 3;
  localparam int FLAG_VALID = 0;
  localparam int FLAG_WR    = 1;
  localparam int FLAG_EX    = 2;

endpackage

// File: rtl/ctlb_entry_store.sv
module ctlb_entry_store #(
  parameter int SET_BITS = 4,
  parameter int WAY_BITS = 2,
  parameter int CTX_W    = 8,
  parameter int VPN_W    = 19,
  parameter int FLG_W    = 3,
  localparam int IDX_W   = SET_BITS + WAY_BITS,
  localparam int NSETS   = 1 << SET_BITS,
  localparam int NWAYS   = 1 << WAY_BITS,
  localparam int NENT    = NSETS * NWAYS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_hi,
  input  logic                            wr_lo,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [CTX_W-1:0]                wr_tag,
  input  logic [VPN_W-1:0]                wr_vpn,
  input  logic [VPN_W-1:0]                wr_pfn,
  input  logic [FLG_W-1:0]                wr_flg,
  input  logic [SET_BITS-1:0]             lk_set,
  output logic [NWAYS-1:0][CTX_W-1:0]     lk_tag,
  output logic [NWAYS-1:0][VPN_W-1:0]     lk_vpn,
  output logic [NWAYS-1:0][VPN_W-1:0]     lk_pfn,
  output logic [NWAYS-1:0][FLG_W-1:0]     lk_flg,
  output logic [CTX_W-1:0]                rd_tag,
  output logic [VPN_W-1:0]                rd_vpn,
  output logic [VPN_W-1:0]                rd_pfn,
  output logic [FLG_W-1:0]                rd_flg
);

  localparam logic [CTX_W-1:0] INV_TAG = '1;

  logic [CTX_W-1:0] tag_q [NENT];
  logic [VPN_W-1:0] vpn_q [NENT];
  logic [VPN_W-1:0] pfn_q [NENT];
  logic [FLG_W-1:0] flg_q [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NENT; k++) begin
        tag_q[k] <= INV_TAG;
        vpn_q[k] <= '0;
        pfn_q[k] <= '0;
        flg_q[k] <= '0;
      end
    end else begin
      if (wr_hi) begin
        tag_q[wr_idx] <= wr_tag;
        vpn_q[wr_idx] <= wr_vpn;
      end
      if (wr_lo) begin
        pfn_q[wr_idx] <= wr_pfn;
        flg_q[wr_idx] <= wr_flg;
      end
    end
  end

  // One read tap per way of the addressed set: entry index is {way, set}.
  for (genvar w = 0; w < NWAYS; w++) begin : g_tap
    localparam logic [WAY_BITS-1:0] WSEL = WAY_BITS'(w);
    assign lk_tag[w] = tag_q[{WSEL, lk_set}];
    assign lk_vpn[w] = vpn_q[{WSEL, lk_set}];
    assign lk_pfn[w] = pfn_q[{WSEL, lk_set}];
    assign lk_flg[w] = flg_q[{WSEL, lk_set}];
  end

  assign rd_tag = tag_q[wr_idx];
  assign rd_vpn = vpn_q[wr_idx];
  assign rd_pfn = pfn_q[wr_idx];
  assign rd_flg = flg_q[wr_idx];

endmodule

// File: rtl/ctlb_way_cmp.sv
module ctlb_way_cmp #(
  parameter int CTX_W = 8,
  parameter int VPN_W = 19
) (
  input  logic [CTX_W-1:0] ent_tag,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic             ent_valid,
  input  logic [CTX_W-1:0] cur_tag,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             match
);

  localparam logic [CTX_W-1:0] INV_TAG = '1;

  logic tag_ok;
  logic vpn_ok;

  // The reserved tag is refused in hardware, whatever the context holds.
  assign tag_ok = (ent_tag == cur_tag) && (ent_tag != INV_TAG);
  assign vpn_ok = (ent_vpn == req_vpn);
  assign match  = ent_valid && tag_ok && vpn_ok;

endmodule

// File: rtl/ctlb_way_pick.sv
module ctlb_way_pick #(
  parameter int NWAYS = 4,
  parameter int PFN_W = 19,
  parameter int FLG_W = 3
) (
  input  logic [NWAYS-1:0]              match,
  input  logic [NWAYS-1:0][PFN_W-1:0]   pfn,
  input  logic [NWAYS-1:0][FLG_W-1:0]   flg,
  output logic                          hit,
  output logic [PFN_W-1:0]              pfn_o,
  output logic [FLG_W-1:0]              flg_o
);

  always_comb begin
    pfn_o = '0;
    flg_o = '0;
    // Scan downward so the lowest matching way is assigned last and wins.
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        pfn_o = pfn[w];
        flg_o = flg[w];
      end
    end
  end

  assign hit = |match;

endmodule

// File: rtl/ctlb_top.sv
module ctlb_top
  import ctlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 4,
  parameter int WAY_BITS  = 2,
  parameter int CTX_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [31:0]       rsp_pa,
  output logic              rsp_wr,
  output logic              rsp_ex,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam int VPN_W = ADDR_W - PAGE_BITS;
  localparam int IDX_W = SET_BITS + WAY_BITS;
  localparam int NWAYS = 1 << WAY_BITS;

  logic [IDX_W-1:0]  sel_q;
  logic [ADDR_W-1:0] ctx_q;

  logic wr_sel, wr_hi, wr_lo, wr_ctx;
  assign wr_sel = reg_wr && (reg_addr == WIN_SEL);
  assign wr_hi  = reg_wr && (reg_addr == WIN_HI);
  assign wr_lo  = reg_wr && (reg_addr == WIN_LO);
  assign wr_ctx = reg_wr && (reg_addr == WIN_CTX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ctx_q <= '0;
    end else begin
      if (wr_sel) sel_q <= reg_wdata[IDX_W-1:0];
      if (wr_ctx) ctx_q <= reg_wdata;
    end
  end

  logic [VPN_W-1:0]                req_vpn;
  logic [SET_BITS-1:0]             req_set;
  logic [NWAYS-1:0][CTX_W-1:0]     lk_tag;
  logic [NWAYS-1:0][VPN_W-1:0]     lk_vpn;
  logic [NWAYS-1:0][VPN_W-1:0]     lk_pfn;
  logic [NWAYS-1:0][FLAG_N-1:0]    lk_flg;
  logic [CTX_W-1:0]                rd_tag;
  logic [VPN_W-1:0]                rd_vpn;
  logic [VPN_W-1:0]                rd_pfn;
  logic [FLAG_N-1:0]               rd_flg;

  assign req_vpn = req_va[ADDR_W-1:PAGE_BITS];
  assign req_set = req_va[PAGE_BITS +: SET_BITS];

  ctlb_entry_store #(
    .SET_BITS (SET_BITS),
    .WAY_BITS (WAY_BITS),
    .CTX_W    (CTX_W),
    .VPN_W    (VPN_W),
    .FLG_W    (FLAG_N)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hi  (wr_hi),
    .wr_lo  (wr_lo),
    .wr_idx (sel_q),
    .wr_tag (reg_wdata[CTX_W-1:0]),
    .wr_vpn (reg_wdata[ADDR_W-1:PAGE_BITS]),
    .wr_pfn (reg_wdata[ADDR_W-1:PAGE_BITS]),
    .wr_flg (reg_wdata[FLAG_N-1:0]),
    .lk_set (req_set),
    .lk_tag (lk_tag),
    .lk_vpn (lk_vpn),
    .lk_pfn (lk_pfn),
    .lk_flg (lk_flg),
    .rd_tag (rd_tag),
    .rd_vpn (rd_vpn),
    .rd_pfn (rd_pfn),
    .rd_flg (rd_flg)
  );

  logic [NWAYS-1:0] way_match;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    ctlb_way_cmp #(
      .CTX_W (CTX_W),
      .VPN_W (VPN_W)
    ) u_cmp (
      .ent_tag   (lk_tag[w]),
      .ent_vpn   (lk_vpn[w]),
      .ent_valid (lk_flg[w][FLAG_VALID]),
      .cur_tag   (ctx_q[CTX_W-1:0]),
      .req_vpn   (req_vpn),
      .match     (way_match[w])
    );
  end

  logic              pick_hit;
  logic [VPN_W-1:0]  pick_pfn;
  logic [FLAG_N-1:0] pick_flg;

  ctlb_way_pick #(
    .NWAYS (NWAYS),
    .PFN_W (VPN_W),
    .FLG_W (FLAG_N)
  ) u_pick (
    .match (way_match),
    .pfn   (lk_pfn),
    .flg   (lk_flg),
    .hit   (pick_hit),
    .pfn_o (pick_pfn),
    .flg_o (pick_flg)
  );

  // Pass-through handshake: the lookup has no storage stage.
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
  assign rsp_hit   = pick_hit;
  assign rsp_pa    = pick_hit ? {pick_pfn, req_va[PAGE_BITS-1:0]} : '0;
  assign rsp_wr    = pick_hit && pick_flg[FLAG_WR];
  assign rsp_ex    = pick_hit && pick_flg[FLAG_EX];

  logic [ADDR_W-1:0] hi_word;
  logic [ADDR_W-1:0] lo_word;

  always_comb begin
    hi_word = '0;
    hi_word[ADDR_W-1:PAGE_BITS] = rd_vpn;
    hi_word[CTX_W-1:0]          = rd_tag;
    lo_word = '0;
    lo_word[ADDR_W-1:PAGE_BITS] = rd_pfn;
    lo_word[FLAG_N-1:0]         = rd_flg;
  end

  always_comb begin
    unique case (reg_addr)
      WIN_SEL: reg_rdata = {{(ADDR_W-IDX_W){1'b0}}, sel_q};
      WIN_HI:  reg_rdata = hi_word;
      WIN_LO:  reg_rdata = lo_word;
      default: reg_rdata = ctx_q;
    endcase
  end

endmodule

// File: rtl/ctlb_checker.sv
module ctlb_checker #(
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = 6,
  parameter int CTX_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [31:0]      rsp_pa,
  input logic             rsp_wr,
  input logic             rsp_ex,
  input logic [31:0]      req_va,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [IDX_W-1:0] sel_q,
  input logic [31:0]      ctx_q
);

  // R7: a hit can never happen while the running context is the reserved one
  p_reserved_ctx_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (ctx_q[CTX_W-1:0] != {CTX_W{1'b1}}));

  // R8: the page offset passes through untouched on a hit
  p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_pa[PAGE_BITS-1:0] == req_va[PAGE_BITS-1:0]));

  // R8: a miss drives a zero address and no permissions
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_pa == '0 && !rsp_wr && !rsp_ex));

  // R2: a select write lands in the index register one cycle later
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (sel_q == $past(reg_wdata[IDX_W-1:0])));

  // R10: a stalled result with a held address and no window write stays stable
  p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rsp_valid && !rsp_ready && !reg_wr) && rsp_valid && $stable(req_va))
      |-> ($stable(rsp_pa) && $stable(rsp_hit) && $stable(rsp_wr) && $stable(rsp_ex)));

endmodule

bind ctlb_top ctlb_checker #(
  .PAGE_BITS (PAGE_BITS),
  .IDX_W     (IDX_W),
  .CTX_W     (CTX_W)
) u_ctlb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_hit   (rsp_hit),
  .rsp_pa    (rsp_pa),
  .rsp_wr    (rsp_wr),
  .rsp_ex    (rsp_ex),
  .req_va    (req_va),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sel_q     (sel_q),
  .ctx_q     (ctx_q)
);

// File: tb/ctlb_top_bench.sv
module ctlb_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_hit;
  logic [31:0] rsp_pa;
  logic        rsp_wr;
  logic        rsp_ex;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model of the entry array, built from the requirements.
  logic [7:0]  m_tag [64];
  logic [18:0] m_vpn [64];
  logic [31:0] m_lo  [64];
  logic [31:0] m_ctx = '0;

  always #5 clk = ~clk;

  ctlb_top u_ctlb_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_va    (req_va),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_pa    (rsp_pa),
    .rsp_wr    (rsp_wr),
    .rsp_ex    (rsp_ex),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic win_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd3) m_ctx = d;
  endtask

  task automatic win_rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic prog(input int idx, input logic [31:0] hi, input logic [31:0] lo);
    win_wr(2'd0, 32'(idx));
    win_wr(2'd1, hi);
    win_wr(2'd2, lo);
    m_tag[idx] = hi[7:0];
    m_vpn[idx] = hi[31:13];
    m_lo[idx]  = lo & 32'hFFFF_E007;
  endtask

  function automatic logic [34:0] model_lookup(input logic [31:0] va);
    logic [34:0] r;
    r = '0;
    for (int w = 3; w >= 0; w--) begin
      int idx;
      idx = w * 16 + int'(va[16:13]);
      if (m_lo[idx][0] && m_tag[idx] == m_ctx[7:0] && m_tag[idx] != 8'hFF &&
          m_vpn[idx] == va[31:13])
        r = {1'b1, m_lo[idx][1], m_lo[idx][2], m_lo[idx][31:13], va[12:0]};
    end
    return r;
  endfunction

  task automatic lk_chk(input string req, input logic [31:0] va);
    @(negedge clk);
    req_va = va; req_valid = 1'b1; rsp_ready = 1'b1;
    #1;
    chk(req, {29'd0, rsp_hit, rsp_wr, rsp_ex, rsp_pa}, {29'd0, model_lookup(va)});
  endtask

  function automatic logic [18:0] vpn_of(input int i);
    return 19'h2A000 | 19'(((i / 16) + 1) << 4) | 19'(i % 16);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [34:0] e;
    for (int i = 0; i < 64; i++) begin
      m_tag[i] = 8'hFF; m_vpn[i] = '0; m_lo[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    win_rd(2'd0, d); chk("R1 sel", 64'(d), 64'd0);
    win_rd(2'd3, d); chk("R1 ctx", 64'(d), 64'd0);
    for (int i = 0; i < 64; i++) begin
      win_wr(2'd0, 32'(i));
      win_rd(2'd1, d); chk("R1 hi", 64'(d), 64'h0000_00FF);
      win_rd(2'd2, d); chk("R1 lo", 64'(d), 64'd0);
    end
    lk_chk("R1 lookup", 32'h0000_0000);
    chk("R1 miss", 64'(rsp_hit), 64'd0);

    // R2: select keeps only the low six bits
    for (int i = 0; i < 64; i += 9) begin
      win_wr(2'd0, 32'hFFFF_FFC0 | 32'(i));
      win_rd(2'd0, d); chk("R2 sel", 64'(d), 64'(i));
    end

    // Fill all 64 entries; junk in unused bits must read back as 0
    for (int i = 0; i < 64; i++) begin
      logic [31:0] hi, lo;
      hi = {vpn_of(i), 5'h1F, 8'(i % 3)};
      lo = {19'h01000 + 19'(i * 13), 10'h3FF, i[1], i[0], 1'b1};
      prog(i, hi, lo);
    end
    for (int i = 0; i < 64; i++) begin
      win_wr(2'd0, 32'(i));
      win_rd(2'd1, d); chk("R3 hi readback", 64'(d), 64'({m_vpn[i], 5'd0, m_tag[i]}));
      win_rd(2'd2, d); chk("R4 lo readback", 64'(d), 64'(m_lo[i]));
    end

    // R3/R4: rewriting one word leaves the other alone
    win_wr(2'd0, 32'd10);
    win_wr(2'd1, {vpn_of(10), 13'(10 % 3)});
    win_rd(2'd2, d); chk("R3 lo untouched", 64'(d), 64'(m_lo[10]));
    win_wr(2'd2, m_lo[10]);
    win_rd(2'd1, d); chk("R4 hi untouched", 64'(d), 64'({m_vpn[10], 5'd0, m_tag[10]}));

    // R5/R6/R8: sweep every entry under three contexts with junk upper bits
    for (int c = 0; c < 3; c++) begin
      win_wr(2'd3, 32'h9A5C_3E00 | 32'(c));
      win_rd(2'd3, d); chk("R6 ctx readback", 64'(d), 64'(32'h9A5C_3E00 | 32'(c)));
      for (int i = 0; i < 64; i++) begin
        logic [31:0] va;
        va = {vpn_of(i), 13'((i * 157 + c * 11) & 32'h1FFF)};
        lk_chk("R5 R6 R8 sweep", va);
        e = model_lookup(va);
        chk("R5 hit pattern", 64'(rsp_hit), 64'(m_tag[i] == 8'(c)));
        lk_chk("R5 vpn mismatch", va ^ 32'h8000_0000);
      end
    end

    // R7: invalidate by tag rewrite, and reserved tag with context low byte 0xFF
    win_wr(2'd3, 32'h0000_0002);
    lk_chk("R5 before invalidate", {vpn_of(5), 13'h123});
    chk("R5 hit before invalidate", 64'(rsp_hit), 64'd1);
    prog(5, {vpn_of(5), 13'h0FF}, 32'd0);
    lk_chk("R7 invalidated", {vpn_of(5), 13'h123});
    chk("R7 invalidated miss", 64'(rsp_hit), 64'd0);
    prog(6, {vpn_of(6), 13'h0FF}, 32'h0055_6007);
    win_wr(2'd3, 32'h1234_56FF);
    lk_chk("R7 reserved ctx", {vpn_of(6), 13'h010});
    chk("R7 reserved miss", 64'(rsp_hit), 64'd0);

    // R5: valid flag clear blocks the hit
    win_wr(2'd3, 32'd1);
    prog(7, {vpn_of(7), 13'd1}, 32'h0077_E006);
    lk_chk("R5 invalid flag", {vpn_of(7), 13'h1FF});
    chk("R5 invalid flag miss", 64'(rsp_hit), 64'd0);

    // R9: three ways of set 3 share page and tag; lowest way wins
    prog(3,  {19'h11113, 13'd1}, {19'h0AAAA, 13'h3});
    prog(19, {19'h11113, 13'd1}, {19'h0BBBB, 13'h5});
    prog(35, {19'h11113, 13'd1}, {19'h0CCCC, 13'h7});
    lk_chk("R9 lowest way", {19'h11113, 13'h0ABC});
    chk("R9 way0 pa", 64'(rsp_pa), 64'({19'h0AAAA, 13'h0ABC}));
    prog(3, {19'h11113, 13'h0FF}, 32'd0);
    lk_chk("R9 next way", {19'h11113, 13'h0ABC});
    chk("R9 way1 pa", 64'(rsp_pa), 64'({19'h0BBBB, 13'h0ABC}));

    // R10: pass-through handshake and stall stability
    @(negedge clk);
    req_valid = 1'b1; rsp_ready = 1'b0; req_va = {19'h11113, 13'h0042};
    #1;
    chk("R10 ready follows", 64'(req_ready), 64'd0);
    chk("R10 valid follows", 64'(rsp_valid), 64'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R10 stalled pa", 64'(rsp_pa), 64'({19'h0BBBB, 13'h0042}));
    end
    rsp_ready = 1'b1; #1;
    chk("R10 ready released", 64'(req_ready), 64'd1);
    req_valid = 1'b0; #1;
    chk("R10 valid drop", 64'(rsp_valid), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule